// File: doc/BRIEF.md
# Round-Robin Interleaved Processing Datapath

This block keeps a stream of one data word per clock flowing through a processing function that is allowed several clocks to settle. It holds a parameterised number of identical processing lanes. A rotating slot counter gives each clock cycle to exactly one lane, so consecutive input words are spread across the lanes in turn. Each lane captures its operand on its own slot and keeps it stable for a whole rotation of the counter. The lane then samples its result on its next slot, one full rotation later.

An output selector follows the same rotation one cycle behind. Every clock it copies the result of the lane that finished on the previous edge into a single output register. Words therefore leave in arrival order at the full input rate, after a fixed delay. Input and output are qualified by a valid flag, and a cycle with the input valid flag low travels through the lanes as a bubble. The lane function is fixed: the word is multiplied by 3, 7 is added, and the result is truncated to the data width.

Top module: `ilv_datapath`

## Requirements
- R1: While `rst_n` is low at a clock edge, the slot counter returns to lane 0 and every valid flag is cleared, so `out_valid` is low after that edge.
- R2: For every valid output word, `out_data` equals (input word × 3 + 7) modulo 2^DATA_W.
- R3: A word sampled with `in_valid` high at clock edge t appears on the outputs with `out_valid` high just after clock edge t+LANES+1.
- R4: Output words leave in the same order in which the input words were accepted.
- R5: An unbroken run of valid input words, one per clock, produces an unbroken run of valid output words, one per clock.
- R6: A cycle with `in_valid` low yields `out_valid` low exactly LANES+1 cycles later, and the data applied during that cycle never appears as a valid output.
- R7: A lane's operand and result registers change only at the edges where that lane holds the slot, which is once every LANES cycles.
- R8: Exactly one lane holds the slot in every cycle, and the slot moves to the next lane on every clock whatever the input valid flag is. Lane LANES-1 is followed by lane 0.
- R9: With LANES = 1 the block acts as a single lane with a latency of 2 cycles.
- R10: A reset applied while words are in flight discards those words. No valid output appears until new words have been accepted and have completed the latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers sample on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_data` as a word to process this cycle |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Marks `out_data` as a processed word |
| out_data | output | DATA_W | Processed word, meaningful only while `out_valid` is high |

## Verification
Every result is due a fixed LANES+1 edges after its input was sampled, and a bubble has the same timing. The bench therefore keeps a history of the words sampled at each edge and, shortly after each edge, compares each instance's outputs with the history entry LANES+1 edges back. Three instances with lane counts 1, 2 and 4 share the same stimulus, so a single stream exercises several rotation lengths at once. Dense streams, scattered bubbles and an alternating pattern are used, and a reset in mid-stream must empty the history and the outputs together.

// File: rtl/ilv_pkg.sv
// Shared constants of the interleaved datapath.
// Assumes: the lane function is x*ILV_MULT + ILV_OFFSET, truncated to the data width.
package ilv_pkg;
    localparam int ILV_MULT   = 3;
    localparam int ILV_OFFSET = 7;

    // Width of a lane index, never below one bit.
    function automatic int idx_width(input int lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction
endpackage

// File: rtl/ilv_rotator.sv
// Slot rotator: a modulo-LANES counter decoded into one-hot load enables.
// Assumes: advances every clock; the enables are clock enables, not derived clocks.
module ilv_rotator #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [LANES-1:0] slot
);
    import ilv_pkg::*;
    localparam int IDX_W = idx_width(LANES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

    logic [IDX_W-1:0] idx;

    // Step the lane index, wrapping after the last lane.
    always_ff @(posedge clk) begin
        if (!rst_n)           idx <= '0;
        else if (idx == LAST) idx <= '0;
        else                  idx <= idx + 1'b1;
    end

    // Decode the index into one enable per lane.
    for (genvar k = 0; k < LANES; k++) begin : g_dec
        assign slot[k] = (idx == IDX_W'(k));
    end

    // Checker state: previous slot vector and a flag for one cycle after reset.
    logic             was_run;
    logic [LANES-1:0] slot_q;
    logic [LANES-1:0] slot_exp;

    // Capture history for the step check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_run <= 1'b0;
            slot_q  <= '0;
        end else begin
            was_run <= 1'b1;
            slot_q  <= slot;
        end
    end

    // Expected slot: previous one rotated up by one lane.
    always_comb begin
        for (int k = 0; k < LANES; k++) slot_exp[k] = slot_q[(k + LANES - 1) % LANES];
    end

    // R8
    slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot) == 1);
    // R8
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        was_run |-> slot == slot_exp);
endmodule

// File: rtl/ilv_lane.sv
// One processing lane: operand register loaded on its slot, result sampled one rotation later.
// Assumes: load is high once every LANES cycles; the function path has LANES cycles to settle.
module ilv_lane #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    import ilv_pkg::*;

    logic              opnd_v;
    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] func_out;

    // Lane function on the held operand (multicycle path).
    assign func_out = DATA_W'(opnd * DATA_W'(ILV_MULT) + DATA_W'(ILV_OFFSET));

    // On its slot: retire the old operand's result and take the new operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_v    <= 1'b0;
            opnd      <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else if (load) begin
            opnd_v    <= in_valid;
            opnd      <= in_data;
            res_valid <= opnd_v;
            res_data  <= func_out;
        end
    end

    // Checker flag: one cycle past reset.
    logic was_run;
    always_ff @(posedge clk) begin
        if (!rst_n) was_run <= 1'b0;
        else        was_run <= 1'b1;
    end

    // R7
    opnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run && !$past(load)) |-> ($stable(opnd) && $stable(opnd_v)));
    // R7
    rslt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run && !$past(load)) |-> ($stable(res_data) && $stable(res_valid)));
endmodule

// File: rtl/ilv_outmux.sv
// Output recombiner: picks the lane that finished on the previous edge into one register.
// Assumes: slot is one-hot; lane buses are packed lane 0 in the low bits.
module ilv_outmux #(
    parameter int LANES  = 4,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        slot,
    input  logic [LANES-1:0]        lane_valid,
    input  logic [LANES*DATA_W-1:0] lane_data,
    output logic                    out_valid,
    output logic [DATA_W-1:0]       out_data
);
    logic [LANES-1:0]  pick;
    logic              mux_v;
    logic [DATA_W-1:0] mux_d;

    // Delay the slot by one cycle: that lane has just sampled its result.
    always_ff @(posedge clk) begin
        if (!rst_n) pick <= '0;
        else        pick <= slot;
    end

    // One-hot AND-OR selection of the finished lane.
    always_comb begin
        mux_v = 1'b0;
        mux_d = '0;
        for (int k = 0; k < LANES; k++) begin
            mux_v = mux_v | (pick[k] & lane_valid[k]);
            mux_d = mux_d | ({DATA_W{pick[k]}} & lane_data[k*DATA_W +: DATA_W]);
        end
    end

    // Output register, updated every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= mux_v;
            out_data  <= mux_d;
        end
    end

    // R4
    pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick));
endmodule

// File: rtl/ilv_datapath.sv
// Top: rotator, LANES identical lanes and the output recombiner.
// Assumes: one input word per clock at most; fixed latency LANES+1.
module ilv_datapath #(
    parameter int LANES  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int BUS_W = LANES * DATA_W;

    logic [LANES-1:0] slot;
    logic [LANES-1:0] lane_valid;
    logic [BUS_W-1:0] lane_data;

    ilv_rotator #(.LANES(LANES)) u_rot (
        .clk  (clk),
        .rst_n(rst_n),
        .slot (slot)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        ilv_lane #(.DATA_W(DATA_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (slot[k]),
            .in_valid (in_valid),
            .in_data  (in_data),
            .res_valid(lane_valid[k]),
            .res_data (lane_data[k*DATA_W +: DATA_W])
        );
    end

    ilv_outmux #(.LANES(LANES), .DATA_W(DATA_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .lane_valid(lane_valid),
        .lane_data (lane_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Checker flag: one cycle past reset.
    logic was_run;
    always_ff @(posedge clk) begin
        if (!rst_n) was_run <= 1'b0;
        else        was_run <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        (rst_n && !was_run) |-> !out_valid);
endmodule

// File: tb/ilv_datapath_test.sv
`timescale 1ns/1ps
module ilv_datapath_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;

    logic         ov1, ov2, ov4;
    logic [W-1:0] od1, od2, od4;

    int tests = 0;
    int fails = 0;

    logic         hist_v [0:5];
    logic [W-1:0] hist_d [0:5];

    always #4 clk = ~clk;

    ilv_datapath #(.LANES(4), .DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov4), .out_data(od4));
    ilv_datapath #(.LANES(2), .DATA_W(W)) uut_n2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov2), .out_data(od2));
    ilv_datapath #(.LANES(1), .DATA_W(W)) uut_n1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov1), .out_data(od1));

    function automatic logic [W-1:0] ref_f(input logic [W-1:0] x);
        return W'(x * 3 + 7);
    endfunction

    // Compare one instance against the input sampled LANES+1 edges ago.
    task automatic check_inst(input int n, input logic v, input logic [W-1:0] d, input string tag);
        tests++;
        if (v !== hist_v[n+1]) begin
            fails++;
            $display("FAIL %s lanes=%0d out_valid actual=%0b expected=%0b", tag, n, v, hist_v[n+1]);
        end else if (v) begin
            tests++;
            if (d !== ref_f(hist_d[n+1])) begin
                fails++;
                $display("FAIL %s lanes=%0d out_data actual=%0h expected=%0h",
                         tag, n, d, ref_f(hist_d[n+1]));
            end
        end
    endtask

    // Apply one input, pass an edge, update history, check all instances.
    task automatic tick(input logic v, input logic [W-1:0] d, input string tag);
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        if (!rst_n) begin
            for (int k = 0; k < 6; k++) begin hist_v[k] = 1'b0; hist_d[k] = '0; end
        end else begin
            for (int k = 5; k > 0; k--) begin hist_v[k] = hist_v[k-1]; hist_d[k] = hist_d[k-1]; end
            hist_v[0] = v;
            hist_d[0] = d;
        end
        #2;
        check_inst(1, ov1, od1, tag);
        check_inst(2, ov2, od2, tag);
        check_inst(4, ov4, od4, tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) tick(1'b1, W'(16'h00AA + i), "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) tick(1'b0, '0, "R1");
    endtask

    task automatic t_stream();
        for (int i = 0; i < 40; i++) tick(1'b1, W'(i * 37 + 5), "R2 R3 R4 R5 R9");
        for (int i = 0; i < 6; i++) tick(1'b0, W'(16'hFFFF), "R3 R6");
    endtask

    task automatic t_bubbles();
        for (int i = 0; i < 40; i++)
            tick((i % 3) != 1, W'(16'hF000 + i * 11), "R6 R7 R8");
        for (int i = 0; i < 6; i++) tick(1'b0, '0, "R6");
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 24; i++) tick(i[0], (i[0] ? W'(16'hFFFF - i) : W'(16'h5555)), "R4 R6 R8");
        for (int i = 0; i < 6; i++) tick(1'b0, '0, "R6");
    endtask

    task automatic t_midreset();
        for (int i = 0; i < 5; i++) tick(1'b1, W'(16'h1230 + i), "R10");
        rst_n = 1'b0;
        tick(1'b1, W'(16'h7777), "R10");
        tick(1'b1, W'(16'h8888), "R10");
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) tick(1'b1, W'(16'h0100 + i), "R10 R1");
        for (int i = 0; i < 6; i++) tick(1'b0, '0, "R10");
    endtask

    initial begin
        for (int k = 0; k < 6; k++) begin hist_v[k] = 1'b0; hist_d[k] = '0; end
        t_reset();
        t_stream();
        t_bubbles();
        t_alternate();
        t_midreset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule